// File: doc/BRIEF.md
# Power-Management Event Status, Enable and Timer Block

This block holds a 16-bit event status register, a 16-bit event enable register and a free-running power-management timer. It combines them into a level-sensitive system control interrupt. Software reaches the registers through a simple byte-addressed register bus. The timer advances once for each pulse on a tick-enable input, and those pulses come at the timer reference rate. The default counter width is 24 bits.

Single-cycle pulse inputs report three things: a power button press, a wake event with a cause code, and a level input for pending general-purpose events. The block sets sticky status bits from these inputs. Software clears a status bit by writing a 1 to it. The interrupt output is high while any enabled event in the interrupt group is pending, or while the external general-purpose term is high.

Each time the top bit of the timer toggles, the timer-carry status flag is set. If timer wake is enabled and the flag was clear beforehand, the block also emits a one-cycle timer wake request.

Top module: `pm_evt_timer`

## Requirements
- R1: The enable register is read and written at byte offset 2 with a 16-bit access (`busSize`=1). The status register is read at offset 0 with a 16-bit access. A read with any other offset/size pair (other than the timer, R3) returns 0. A write with any size other than 16-bit to offset 0 or 2 has no effect. `busSize` encoding: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit.
- R2: A 16-bit write to offset 0 clears every status bit that is 1 in `busWdata[15:0]`. All other status bits are left unchanged.
- R3: A 32-bit read at offset 8 returns the timer counter in the low `TMR_W` bits, with the upper bits 0. The counter increments by one on each cycle with `tickEn`=1 and wraps from all-ones to 0. Writes to offset 8 are ignored.
- R4: Status bit 0 (timer carry) is set on the edge where a tick makes counter bit `TMR_W-1` toggle, that is, when the low `TMR_W-1` bits are all ones. This includes the wrap to 0. The bit stays set until software clears it.
- R5: A `pwrBtn` pulse sets status bit 8 only when enable bit 8 is 1.
- R6: `sciOut` = ((status AND enable AND mask) != 0) OR `gpePending`. The mask covers bits 0, 5, 8, 9 and 10. Bit 15 is never part of the interrupt.
- R7: A `wakeStrobe` pulse always sets status bit 15 together with a cause bit, chosen by `wakeCause`: 0 sets bit 10 (alarm), 1 sets bit 0 (timer), and 2 or 3 set bit 8 (power button). The enable register does not gate this.
- R8: Reset clears status, enable, the timer counter and the timer wake request.
- R9: `timerWakeReq` is high for exactly the one cycle after the edge on which the timer carry sets status bit 0. This happens only if enable bit 0 was 1 and status bit 0 was 0 before that edge.
- R10: When a hardware set and a software clear hit the same status bit on the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset |
| busSize | input | 2 | Access size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| busWdata | input | BUS_W | Write data |
| busRdata | output | BUS_W | Read data, valid in the same cycle as a read |
| tickEn | input | 1 | One pulse per timer reference period |
| pwrBtn | input | 1 | Power button pulse |
| wakeStrobe | input | 1 | Wake event pulse |
| wakeCause | input | 2 | Wake cause code |
| gpePending | input | 1 | External general-purpose event term |
| sciOut | output | 1 | Level interrupt |
| timerWakeReq | output | 1 | One-cycle timer wake request |

## Verification
Read data and `sciOut` are combinational from the registers. Writes, pulses and ticks take effect at the clock edge that samples them. The bench therefore drives every input at a falling edge and samples results at the following falling edge, after exactly one rising edge has passed. `timerWakeReq` is registered alongside the status flag, so the bench samples it half a cycle after the crossing tick's edge and again one cycle later to confirm that it has dropped. The bench shortens the timer to 12 bits so that both top-bit crossings, and the wrap, fall within a short run.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W = 16;
  localparam int BIT_TMR  = 0;
  localparam int BIT_GBL  = 5;
  localparam int BIT_PWR  = 8;
  localparam int BIT_SLP  = 9;
  localparam int BIT_RTC  = 10;
  localparam int BIT_WAKE = 15;
  localparam logic [REG_W-1:0] SCI_MASK =
    REG_W'((1 << BIT_TMR) | (1 << BIT_GBL) | (1 << BIT_PWR) | (1 << BIT_SLP) | (1 << BIT_RTC));

  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [1:0] CAUSE_RTC = 2'd0;
  localparam logic [1:0] CAUSE_TMR = 2'd1;

  typedef struct packed {
    logic stsWr;
    logic enWr;
    logic rdSts;
    logic rdEn;
    logic rdTmr;
  } pmStrobe_t;
endpackage

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int OFF_STS = 0,
  parameter int OFF_EN  = 2,
  parameter int OFF_TMR = 8
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output pmStrobe_t         strb
);
  logic isHalf, isWord, hitSts, hitEn, hitTmr;

  always_comb begin
    isHalf = (busSize == SZ_HALF);
    isWord = (busSize == SZ_WORD);
    hitSts = busValid && (busAddr == ADDR_W'(OFF_STS));
    hitEn  = busValid && (busAddr == ADDR_W'(OFF_EN));
    hitTmr = busValid && (busAddr == ADDR_W'(OFF_TMR));
    strb.stsWr = hitSts && busWrite && isHalf;
    strb.enWr  = hitEn  && busWrite && isHalf;
    strb.rdSts = hitSts && !busWrite && isHalf;
    strb.rdEn  = hitEn  && !busWrite && isHalf;
    strb.rdTmr = hitTmr && !busWrite && isWord;
  end
endmodule

// File: rtl/pm_evt_datapath.sv
module pm_evt_datapath
  import pm_evt_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pmStrobe_t        strb,
  input  logic [BUS_W-1:0] busWdata,
  input  logic             tickEn,
  input  logic             pwrBtn,
  input  logic             wakeStrobe,
  input  logic [1:0]       wakeCause,
  input  logic             gpePending,
  output logic [BUS_W-1:0] busRdata,
  output logic             sciOut,
  output logic             timerWakeReq,
  output logic [REG_W-1:0] stsQ,
  output logic [REG_W-1:0] enQ,
  output logic [TMR_W-1:0] cntQ
);
  logic             carry;
  logic [REG_W-1:0] setMask, stsNext;

  always_comb begin
    carry   = tickEn && (&cntQ[TMR_W-2:0]);
    setMask = '0;
    if (carry)                setMask[BIT_TMR] = 1'b1;
    if (pwrBtn && enQ[BIT_PWR]) setMask[BIT_PWR] = 1'b1;
    if (wakeStrobe) begin
      setMask[BIT_WAKE] = 1'b1;
      case (wakeCause)
        CAUSE_RTC: setMask[BIT_RTC] = 1'b1;
        CAUSE_TMR: setMask[BIT_TMR] = 1'b1;
        default:   setMask[BIT_PWR] = 1'b1;
      endcase
    end
    stsNext = stsQ;
    if (strb.stsWr) stsNext = stsNext & ~busWdata[REG_W-1:0];
    stsNext = stsNext | setMask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stsQ         <= '0;
      enQ          <= '0;
      cntQ         <= '0;
      timerWakeReq <= 1'b0;
    end else begin
      stsQ         <= stsNext;
      if (strb.enWr) enQ <= busWdata[REG_W-1:0];
      if (tickEn)    cntQ <= cntQ + 1'b1;
      timerWakeReq <= carry && enQ[BIT_TMR] && !stsQ[BIT_TMR];
    end
  end

  always_comb begin
    sciOut   = (|(stsQ & enQ & SCI_MASK)) || gpePending;
    busRdata = '0;
    if (strb.rdSts)      busRdata = BUS_W'(stsQ);
    else if (strb.rdEn)  busRdata = BUS_W'(enQ);
    else if (strb.rdTmr) busRdata = BUS_W'(cntQ);
  end
endmodule

// File: rtl/pm_evt_timer.sv
module pm_evt_timer
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BUS_W  = 32,
  parameter int TMR_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              tickEn,
  input  logic              pwrBtn,
  input  logic              wakeStrobe,
  input  logic [1:0]        wakeCause,
  input  logic              gpePending,
  output logic              sciOut,
  output logic              timerWakeReq
);
  pmStrobe_t        strb;
  logic [REG_W-1:0] stsQ, enQ;
  logic [TMR_W-1:0] cntQ;

  pm_evt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .strb(strb)
  );

  pm_evt_datapath #(.BUS_W(BUS_W), .TMR_W(TMR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busWdata(busWdata),
    .tickEn(tickEn), .pwrBtn(pwrBtn), .wakeStrobe(wakeStrobe),
    .wakeCause(wakeCause), .gpePending(gpePending), .busRdata(busRdata),
    .sciOut(sciOut), .timerWakeReq(timerWakeReq),
    .stsQ(stsQ), .enQ(enQ), .cntQ(cntQ)
  );
endmodule

// File: rtl/pm_evt_timer_chk.sv
module pm_evt_timer_chk
  import pm_evt_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tickEn,
  input logic             wakeStrobe,
  input logic             gpePending,
  input logic             sciOut,
  input logic             timerWakeReq,
  input logic [REG_W-1:0] stsQ,
  input logic [REG_W-1:0] enQ,
  input logic [TMR_W-1:0] cntQ
);
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tickEn |=> cntQ == TMR_W'($past(cntQ) + 1'b1));

  a_r4_carry_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && (&cntQ[TMR_W-2:0])) |=> stsQ[BIT_TMR]);

  a_r5_btn_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!stsQ[BIT_PWR] && !enQ[BIT_PWR] && !wakeStrobe) |=> !stsQ[BIT_PWR]);

  a_r6_gpe_drives_sci: assert property (@(posedge clk) disable iff (!rst_n)
    gpePending |-> sciOut);

  a_r7_wake_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wakeStrobe |=> stsQ[BIT_WAKE]);

  a_r9_wake_req: assert property (@(posedge clk) disable iff (!rst_n)
    timerWakeReq |-> (stsQ[BIT_TMR] && $past(enQ[BIT_TMR])));
endmodule

bind pm_evt_timer pm_evt_timer_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .wakeStrobe(wakeStrobe),
  .gpePending(gpePending), .sciOut(sciOut), .timerWakeReq(timerWakeReq),
  .stsQ(stsQ), .enQ(enQ), .cntQ(cntQ)
);

// File: tb/pm_evt_timer_bench.sv
module pm_evt_timer_bench;
  localparam int TW = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic busValid = 0, busWrite = 0;
  logic [3:0] busAddr = '0;
  logic [1:0] busSize = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic tickEn = 0, pwrBtn = 0, wakeStrobe = 0, gpePending = 0;
  logic [1:0] wakeCause = '0;
  logic sciOut, timerWakeReq;
  int nChecks = 0, nFails = 0;
  int tmrModel = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pm_evt_timer #(.TMR_W(TW)) u_pm_evt_timer (
    .clk(clk), .rst_n(rst_n), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .tickEn(tickEn), .pwrBtn(pwrBtn),
    .wakeStrobe(wakeStrobe), .wakeCause(wakeCause), .gpePending(gpePending),
    .sciOut(sciOut), .timerWakeReq(timerWakeReq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; tmrModel = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busSize = sz; busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a; busSize = sz;
    #1 d = busRdata;
    busValid = 0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1;
      @(negedge clk); tickEn = 0;
      tmrModel = (tmrModel + 1) % (1 << TW);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    doReset();
    rd(0, 1, d); chk("R8 status after reset", d, 0);
    rd(2, 1, d); chk("R8 enable after reset", d, 0);
    rd(8, 2, d); chk("R8 timer after reset", d, 0);
    chk("R8 sci after reset", sciOut, 0);
    chk("R8 wake req after reset", timerWakeReq, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(2, 1, 32'hABCD_0521);
    rd(2, 1, d); chk("R1 enable readback", d, 32'h0521);
    wr(2, 0, 32'h0000_00FF);
    rd(2, 1, d); chk("R1 byte write ignored", d, 32'h0521);
    wr(2, 2, 32'h0000_0000);
    rd(2, 1, d); chk("R1 word write ignored", d, 32'h0521);
    rd(4, 1, d); chk("R1 unmapped offset reads 0", d, 0);
    rd(2, 2, d); chk("R1 wrong size read 0", d, 0);
    wr(2, 1, 0);
  endtask

  task automatic t_button();
    logic [31:0] d;
    @(negedge clk); pwrBtn = 1; @(negedge clk); pwrBtn = 0;
    rd(0, 1, d); chk("R5 button masked", d, 0);
    wr(2, 1, 32'h0100);
    @(negedge clk); pwrBtn = 1; @(negedge clk); pwrBtn = 0;
    rd(0, 1, d); chk("R5 button enabled", d, 32'h0100);
    chk("R6 sci from button", sciOut, 1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(0, 1, 32'h0000_FEFF);
    rd(0, 1, d); chk("R2 zeros keep bit", d, 32'h0100);
    wr(0, 1, 32'h0000_0100);
    rd(0, 1, d); chk("R2 one clears bit", d, 0);
    chk("R6 sci low after clear", sciOut, 0);
  endtask

  task automatic t_wake_sci();
    logic [31:0] d;
    wr(2, 1, 32'h8000);
    @(negedge clk); wakeStrobe = 1; wakeCause = 0;
    @(negedge clk); wakeStrobe = 0;
    rd(0, 1, d); chk("R7 alarm wake", d, 32'h8400);
    chk("R6 bit15 not in interrupt", sciOut, 0);
    @(negedge clk); wakeStrobe = 1; wakeCause = 3;
    @(negedge clk); wakeStrobe = 0;
    rd(0, 1, d); chk("R7 other wake", d, 32'h8500);
    @(negedge clk); wakeStrobe = 1; wakeCause = 1;
    @(negedge clk); wakeStrobe = 0;
    rd(0, 1, d); chk("R7 timer wake", d, 32'h8501);
    wr(2, 1, 32'h0400);
    chk("R6 alarm enabled raises sci", sciOut, 1);
    wr(0, 1, 32'hFFFF);
    chk("R6 sci low", sciOut, 0);
    @(negedge clk); gpePending = 1; #1;
    chk("R6 gpe term", sciOut, 1);
    @(negedge clk); gpePending = 0; #1;
    chk("R6 gpe released", sciOut, 0);
    wr(2, 1, 0);
  endtask

  task automatic t_timer();
    logic [31:0] d;
    wr(2, 1, 32'h0001);
    tick(5);
    rd(8, 2, d); chk("R3 count", d, tmrModel);
    wr(8, 2, 32'hFFFF_FFFF);
    rd(8, 2, d); chk("R3 write ignored", d, 5);
    tick((1 << (TW - 1)) - 1 - tmrModel);
    rd(0, 1, d); chk("R4 not yet crossed", d, 0);
    tick(1);
    chk("R9 wake pulse", timerWakeReq, 1);
    rd(0, 1, d); chk("R4 carry set at crossing", d, 32'h0001);
    chk("R9 wake pulse one cycle", timerWakeReq, 0);
    chk("R6 sci from timer", sciOut, 1);
    rd(8, 2, d); chk("R3 count at crossing", d, 1 << (TW - 1));
    tick((1 << TW) - tmrModel);
    chk("R9 no pulse when already set", timerWakeReq, 0);
    rd(8, 2, d); chk("R3 wrap to zero", d, 0);
    wr(0, 1, 32'h0001);
    rd(0, 1, d); chk("R2 carry cleared", d, 0);
    tick(3);
    rd(0, 1, d); chk("R4 stays clear off boundary", d, 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(2, 1, 32'h0100);
    @(negedge clk);
    pwrBtn = 1; busValid = 1; busWrite = 1; busAddr = 0; busSize = 1; busWdata = 32'h0100;
    @(negedge clk);
    pwrBtn = 0; busValid = 0; busWrite = 0;
    rd(0, 1, d); chk("R10 set wins over clear", d, 32'h0100);
  endtask

  task automatic t_midreset();
    logic [31:0] d;
    tick(7);
    doReset();
    rd(0, 1, d); chk("R8 status cleared", d, 0);
    rd(2, 1, d); chk("R8 enable cleared", d, 0);
    rd(8, 2, d); chk("R8 timer cleared", d, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    t_reset();
    t_regs();
    t_button();
    t_w1c();
    t_wake_sci();
    t_timer();
    t_collide();
    t_midreset();
    finishRun();
  end
endmodule